// File: doc/BRIEF.md
# STN Frame-Rate-Control Dithering Unit

This unit sits in the pixel path of a display controller that drives a passive STN panel. Each incoming pixel carries a 4-bit intensity per channel. Such a panel can only switch a dot fully on or fully off, so the unit turns each level into a single on/off bit per channel. Intermediate shades come from driving the dot on in only a fraction of successive frames. The frame-to-frame on/off sequence for each level is held in a programmable pattern register, one 16-bit register per level.

The bit taken from a level's pattern is chosen by a frame counter, the low bits of the pixel's horizontal coordinate and a fixed per-channel offset, all added together. The counter is modulo 16. The horizontal term gives neighbouring dots different phases of the same pattern, and the counter moves those phases on every frame, so adjacent dots do not flicker in step. The three colour subpixels of one dot use different offsets for the same reason.

Software writes new patterns at any time into a shadow bank. The shadow bank is copied into the active bank at the next frame-start strobe, so a frame never mixes old and new patterns. When a TFT panel is selected, the dither decision is switched off and the registered levels pass straight through.

Top module: `frc_dither`

## Requirements
- R1: After reset, out_valid and out_on are 0, the frame counter is 0 and every shadow and active pattern is 0. Until patterns are loaded, every level from 1 to 14 therefore gives off.
- R2: out_valid, out_on and out_lvl are registered with exactly one clock of latency. out_valid equals pix_valid from the previous cycle, and out_lvl equals pix_lvl from the previous cycle, whatever the mode.
- R3: When stn_en is 0 (TFT), out_on is 0 on all channels.
- R4: Level 0 always gives off and level 15 always gives on, whatever their pattern registers hold.
- R5: For a level L from 1 to 14, the channel output is bit ((F + pix_x_lo + K) mod 16) of the active pattern for L. Bit 0 is the LSB, F is the frame counter and K is the channel offset.
- R6: The frame counter increments by one, modulo 16, on each cycle with frame_start high. A pixel presented in that same cycle still uses the old count.
- R7: A write with reg_we high stores reg_wdata as the shadow pattern of level reg_addr. Until the next frame_start it has no effect on out_on.
- R8: A write made in the same cycle as frame_start is included in the patterns loaded at that frame_start. A pixel in that cycle still uses the previous active patterns.
- R9: In colour mode (color_mode=1), red is pix_lvl[11:8] with K=0 and drives out_on[2]. Green is pix_lvl[7:4] with K=1 and drives out_on[1]. Blue is pix_lvl[3:0] with K=2 and drives out_on[0].
- R10: In monochrome mode (color_mode=0), only pix_lvl[11:8] is used, with K=0 on out_on[2]. out_on[1:0] are 0 and the lower two fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stn_en | input | 1 | 1 = STN panel (dither on), 0 = TFT bypass |
| color_mode | input | 1 | 1 = three colour channels, 0 = monochrome |
| frame_start | input | 1 | One-cycle strobe at the start of a frame |
| pix_valid | input | 1 | Pixel qualifier |
| pix_x_lo | input | 4 | Low bits of the pixel's horizontal coordinate |
| pix_lvl | input | 12 | Levels: red [11:8], green [7:4], blue [3:0] |
| reg_we | input | 1 | Pattern register write strobe |
| reg_addr | input | 4 | Level whose pattern is written |
| reg_wdata | input | 16 | Pattern value |
| out_valid | output | 1 | Registered pix_valid |
| out_on | output | 3 | On/off drive: red [2], green [1], blue [0] |
| out_lvl | output | 12 | Registered pix_lvl (TFT path) |

## Verification
Two events can fall in the same cycle: a pattern write and a frame-start strobe. Together these decide which patterns the next frame uses. The bench provokes this collision directly. In the directed part, it writes a distinctive pattern in exactly the frame_start cycle while a pixel of that level is present. The bench then checks two things: that pixel must still follow the old active pattern, and the pixels after it must follow the newly written one. Random traffic then raises reg_we and frame_start independently, so many further collisions occur. A bench-side shadow/active model with the same forwarding rule predicts every output bit.

// File: rtl/frc_pkg.sv
package frc_pkg;
    localparam int LVL_W = 4;
    localparam int NLVL  = 1 << LVL_W;
    localparam int PAT_W = NLVL;
    localparam int IDX_W = $clog2(PAT_W);
    localparam int NCH   = 3;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [PAT_W-1:0] pat_t;
endpackage

// File: rtl/frc_pattern_bank.sv
module frc_pattern_bank
    import frc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  lvl_t                  wr_addr,
    input  pat_t                  wr_data,
    input  logic                  load,
    output logic [NLVL*PAT_W-1:0] active_flat
);
    typedef struct packed {
        logic [NLVL-1:0][PAT_W-1:0] shadow;
        logic [NLVL-1:0][PAT_W-1:0] active;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.shadow[wr_addr] = wr_data;
        end
        if (load) begin
            s_d.active = s_d.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_flat = s_q.active;

    // Active patterns only change at a frame boundary (R7)
    assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(s_q.active));

    // A write in the load cycle reaches the active bank (R8)
    assert_fwd_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wr_en) |=> (s_q.active[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/frc_phase_ctr.sv
module frc_phase_ctr
    import frc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output idx_t phase
);
    idx_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (advance) begin
            cnt_d = cnt_q + idx_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign phase = cnt_q;

    assert_phase_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (cnt_q == $past(cnt_q) + idx_t'(1)));

    assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(cnt_q));
endmodule

// File: rtl/frc_chan_decide.sv
module frc_chan_decide
    import frc_pkg::*;
#(
    parameter int OFFSET = 0
) (
    input  lvl_t                  lvl,
    input  idx_t                  x_lo,
    input  idx_t                  phase,
    input  logic [NLVL*PAT_W-1:0] active_flat,
    output logic                  on
);
    idx_t sel;
    pat_t pat;

    always_comb begin
        sel = phase + x_lo + idx_t'(OFFSET);
        pat = active_flat[lvl*PAT_W +: PAT_W];
        if (lvl == '0) begin
            on = 1'b0;
        end else if (lvl == '1) begin
            on = 1'b1;
        end else begin
            on = pat[sel];
        end
    end
endmodule

// File: rtl/frc_dither.sv
module frc_dither
    import frc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stn_en,
    input  logic                 color_mode,
    input  logic                 frame_start,
    input  logic                 pix_valid,
    input  logic [IDX_W-1:0]     pix_x_lo,
    input  logic [NCH*LVL_W-1:0] pix_lvl,
    input  logic                 reg_we,
    input  logic [LVL_W-1:0]     reg_addr,
    input  logic [PAT_W-1:0]     reg_wdata,
    output logic                 out_valid,
    output logic [NCH-1:0]       out_on,
    output logic [NCH*LVL_W-1:0] out_lvl
);
    typedef struct packed {
        logic                 valid;
        logic [NCH-1:0]       on;
        logic [NCH*LVL_W-1:0] lvl;
    } out_t;

    out_t o_d, o_q;
    logic [NLVL*PAT_W-1:0] active_flat;
    idx_t                  phase;
    logic [NCH-1:0]        dec;

    frc_pattern_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_we),
        .wr_addr     (reg_addr),
        .wr_data     (reg_wdata),
        .load        (frame_start),
        .active_flat (active_flat)
    );

    frc_phase_ctr u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (frame_start),
        .phase   (phase)
    );

    // Channel c: c=0 red (top field), c=1 green, c=2 blue; offset equals c
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        frc_chan_decide #(.OFFSET(c)) u_dec (
            .lvl         (pix_lvl[(NCH-1-c)*LVL_W +: LVL_W]),
            .x_lo        (pix_x_lo),
            .phase       (phase),
            .active_flat (active_flat),
            .on          (dec[c])
        );
    end

    always_comb begin
        o_d       = o_q;
        o_d.valid = pix_valid;
        o_d.lvl   = pix_lvl;
        for (int c = 0; c < NCH; c++) begin
            o_d.on[NCH-1-c] = stn_en && ((c == 0) || color_mode) && dec[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_on    = o_q.on;
    assign out_lvl   = o_q.lvl;

    assert_valid_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(pix_valid) && out_lvl == $past(pix_lvl)));

    assert_tft_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !stn_en |=> (out_on == '0));

    assert_lvl_zero_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stn_en && pix_lvl[NCH*LVL_W-1 -: LVL_W] == '0) |=> !out_on[NCH-1]);

    assert_lvl_full_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stn_en && pix_lvl[NCH*LVL_W-1 -: LVL_W] == '1) |=> out_on[NCH-1]);

    assert_mono_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !color_mode |=> (out_on[NCH-2:0] == '0));
endmodule

// File: tb/frc_dither_bench.sv
module frc_dither_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stn_en = 1'b0, color_mode = 1'b0, frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [3:0]  pix_x_lo = '0;
    logic [11:0] pix_lvl = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        out_valid;
    logic [2:0]  out_on;
    logic [11:0] out_lvl;

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_shadow [16];
    logic [15:0] m_active [16];
    logic [3:0]  m_f;

    always #4 clk = ~clk;

    frc_dither u_frc_dither (
        .clk(clk), .rst_n(rst_n), .stn_en(stn_en), .color_mode(color_mode),
        .frame_start(frame_start), .pix_valid(pix_valid), .pix_x_lo(pix_x_lo),
        .pix_lvl(pix_lvl), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .out_valid(out_valid), .out_on(out_on),
        .out_lvl(out_lvl)
    );

    function automatic logic chan_bit(input logic [3:0] l, input logic [3:0] x,
                                      input int k);
        logic [3:0] s;
        s = m_f + x + 4'(k);
        if (l == 4'd0) return 1'b0;
        if (l == 4'd15) return 1'b1;
        return m_active[l][s];
    endfunction

    function automatic logic [2:0] exp_on();
        logic [2:0] e;
        e = '0;
        if (stn_en) begin
            e[2] = chan_bit(pix_lvl[11:8], pix_x_lo, 0);
            if (color_mode) begin
                e[1] = chan_bit(pix_lvl[7:4], pix_x_lo, 1);
                e[0] = chan_bit(pix_lvl[3:0], pix_x_lo, 2);
            end
        end
        return e;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: predict from current inputs and model, clock, update model, compare.
    task automatic step(input string tag);
        logic [2:0]  e_on;
        logic        e_v;
        logic [11:0] e_l;
        e_on = exp_on();
        e_v  = pix_valid;
        e_l  = pix_lvl;
        @(posedge clk);
        if (reg_we) m_shadow[reg_addr] = reg_wdata;
        if (frame_start) begin
            for (int i = 0; i < 16; i++) m_active[i] = m_shadow[i];
            m_f = m_f + 4'd1;
        end
        #1;
        check({tag, " on"}, {13'd0, out_on}, {13'd0, e_on});
        check("R2 valid", {15'd0, out_valid}, {15'd0, e_v});
        check("R2 lvl", {4'd0, out_lvl}, {4'd0, e_l});
        reg_we = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        for (int i = 0; i < 16; i++) begin m_shadow[i] = '0; m_active[i] = '0; end
        m_f = '0;
        #3;
        // R1: reset state
        check("R1 valid", {15'd0, out_valid}, 16'd0);
        check("R1 on", {13'd0, out_on}, 16'd0);
        #10 rst_n = 1'b1;
        @(negedge clk);
        stn_en = 1'b1; color_mode = 1'b1; pix_valid = 1'b1;
        pix_lvl = 12'h777; pix_x_lo = 4'd5;
        step("R1 zero patterns");

        // R7: write without frame start has no effect yet
        wr(4'd7, 16'hFFFF);
        step("R7 pending write");
        step("R7 still pending");
        frame_start = 1'b1;
        step("R6 old phase in strobe cycle");
        step("R7 applied after frame start");
        check("R7 all on", {13'd0, out_on}, 16'h0007);

        // R8: write coinciding with frame start
        wr(4'd7, 16'h0000);
        frame_start = 1'b1;
        step("R8 same-cycle uses old");
        check("R8 old pattern", {13'd0, out_on}, 16'h0007);
        step("R8 new pattern loaded");
        check("R8 new off", {13'd0, out_on}, 16'h0000);

        // R4: extremes ignore pattern contents
        wr(4'd0, 16'hFFFF); step("R4 write0");
        wr(4'd15, 16'h0000); frame_start = 1'b1; step("R4 write15");
        pix_lvl = 12'h0F0; step("R4 extremes");
        check("R4 extremes", {13'd0, out_on}, 16'h0002);

        // R9: per-channel offsets with a single-bit pattern
        wr(4'd3, 16'h0001); frame_start = 1'b1; step("R9 load");
        for (int x = 0; x < 16; x++) begin
            pix_lvl = 12'h333; pix_x_lo = 4'(x);
            step("R9 offsets");
        end

        // R10: monochrome ignores lower fields
        color_mode = 1'b0; pix_lvl = 12'h0FF; step("R10 mono");
        check("R10 mono", {13'd0, out_on}, 16'h0000);
        // R3: TFT bypass
        stn_en = 1'b0; pix_lvl = 12'hFFF; step("R3 tft");
        check("R3 tft", {13'd0, out_on}, 16'h0000);

        // R5/R6: random traffic
        for (int n = 0; n < 4000; n++) begin
            stn_en      = ($urandom % 8) != 0;
            color_mode  = ($urandom % 4) != 0;
            pix_valid   = $urandom % 2;
            pix_x_lo    = 4'($urandom);
            pix_lvl     = 12'($urandom);
            frame_start = ($urandom % 16) == 0;
            if (($urandom % 6) == 0) wr(4'($urandom), 16'($urandom));
            step("R5 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule